// File: doc/BRIEF.md
# Three-Pin Bidirectional I/O Port

This block is a small general-purpose I/O port of three pins, run from a memory-mapped register interface. Each pin has an output latch bit and a direction bit. A direction bit of 0 drives that pin's latch value onto the pin. A direction bit of 1 releases the driver so the pin becomes an input. Pin levels pass through a two-flop synchronizer before software can read them.

A per-pin analog-select register marks pins that an analog converter uses. For those pins, digital reads of the pin register return zero. The direction bits still control the drivers while a pin is in analog mode. Out of reset every pin is an input and every pin is in analog mode.

Two separate read paths exist. The latch register returns the value stored for output. The pin register returns the synchronized level on the pins. Writing either address loads the output latch.

Reads are handled by a small response machine with two states. `RD_IDLE` is the state with no response pending. `RD_RESP` is the state in which `rvalid` is high and `rdata` holds the word read. Its transitions are:
- `RD_IDLE` to `RD_RESP` when a read strobe is seen.
- `RD_IDLE` stays in `RD_IDLE` with no strobe.
- `RD_RESP` stays in `RD_RESP` on a back-to-back read.
- `RD_RESP` to `RD_IDLE` when no new strobe is seen.

Top module: `gpio_tri_port`

## Requirements
- R1: After reset, `pin_oe` is 000, `pin_out` is 000, `rvalid` is 0, and the direction and analog-select registers read back 111.
- R2: Each `pin_oe[i]` equals the inverse of direction bit i, and each bit is set independently. The direction register is at address 2, bits [2:0].
- R3: `pin_out` always carries the output latch value. The latch register is at address 1, bits [2:0].
- R4: A read of address 1 returns the stored latch value, whatever the level on the pins.
- R5: A write to address 0 (the pin register) loads the output latch exactly as a write to address 1 does. The new value appears on `pin_out` in the cycle after the write strobe.
- R6: A read of address 0 returns the pin levels after two synchronizing flops. Any bit whose analog-select bit (address 3, bits [2:0]) is 1 reads as 0.
- R7: Analog-select bits have no effect on `pin_oe` or `pin_out`.
- R8: Data bits [7:3] of every read are 0. Addresses 4 to 7 read as 0, and writes to them change no register.
- R9: `rvalid` is high exactly in the cycle after each cycle that has `rd_en` high, and `rdata` is valid then.
- R10: The direction and analog-select registers read back the last values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rvalid |
| rvalid | output | 1 | Read response valid, one cycle after rd_en |
| pin_in | input | 3 | Levels sensed on the pins |
| pin_out | output | 3 | Values to drive onto the pins |
| pin_oe | output | 3 | Per-pin driver enable, 1 = driving |

## Verification
The pin-read path is tried with random pin levels under random analog-select masks. This shows whether masking is applied per bit, and whether the pin register is confused with the latch register. The pins are set to the inverse of the latch before latch reads, so a design that reads pins there is caught. Direction writes use patterns with single bits and with mixed bits, which exposes any coupling between bits or an inverted enable. Writes to the unmapped addresses are each followed by a readback of all registers, to prove that nothing changed.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned PORT_W = 3;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned ADR_W  = 3;

    typedef enum logic [ADR_W-1:0] {
        ADR_PINS  = 3'd0,
        ADR_LATCH = 3'd1,
        ADR_DIR   = 3'd2,
        ADR_ANSEL = 3'd3
    } reg_addr_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = PORT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADR_W-1:0] addr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] ansel_q
);
    logic wr_latch, wr_dir, wr_ansel;

    always_comb begin
        wr_latch = 1'b0;
        wr_dir   = 1'b0;
        wr_ansel = 1'b0;
        if (wr_en) begin
            unique case (addr)
                ADR_PINS, ADR_LATCH: wr_latch = 1'b1;
                ADR_DIR:             wr_dir   = 1'b1;
                ADR_ANSEL:           wr_ansel = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '1;
            ansel_q <= '1;
        end else begin
            if (wr_latch) latch_q <= wdata;
            if (wr_dir)   dir_q   <= wdata;
            if (wr_ansel) ansel_q <= wdata;
        end
    end

    // R8: addresses above the map leave every register untouched
    p_unmapped_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > ADR_ANSEL) |=> ($stable(latch_q) && $stable(dir_q) && $stable(ansel_q)));

    // R10: a direction write is reflected next cycle
    p_dir_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_DIR) |=> dir_q == $past(wdata));
endmodule

// File: rtl/gpio_read_fsm.sv
module gpio_read_fsm
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = PORT_W,
    parameter int unsigned DW    = BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [ADR_W-1:0] addr,
    input  logic [WIDTH-1:0] pins_sync,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] ansel_q,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    localparam int unsigned PAD_W = DW - WIDTH;

    rd_state_e        state_q, state_d;
    logic [WIDTH-1:0] sel_word;
    logic [DW-1:0]    rdata_q;

    always_comb begin
        unique case (addr)
            ADR_PINS:  sel_word = pins_sync & ~ansel_q;
            ADR_LATCH: sel_word = latch_q;
            ADR_DIR:   sel_word = dir_q;
            ADR_ANSEL: sel_word = ansel_q;
            default:   sel_word = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = rd_en ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_en ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= {{PAD_W{1'b0}}, sel_word};
    end

    assign rvalid = (state_q == RD_RESP);
    assign rdata  = rdata_q;

    // R9: response follows every strobe, and only strobes
    p_resp_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
    // R8: upper data bits stay clear
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> rdata[DW-1:WIDTH] == '0);
    // R6: analog pins never read as 1 through the pin register
    p_analog_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_PINS) |=> (rdata[WIDTH-1:0] & $past(ansel_q)) == '0);
endmodule

// File: rtl/gpio_tri_port.sv
module gpio_tri_port
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH       = PORT_W,
    parameter int unsigned DW          = BUS_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADR_W-1:0] addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rvalid,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    logic [WIDTH-1:0] pins_sync, latch_q, dir_q, ansel_q;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DW-1:WIDTH];

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pins_sync)
    );

    gpio_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata[WIDTH-1:0]), .latch_q(latch_q), .dir_q(dir_q), .ansel_q(ansel_q)
    );

    gpio_read_fsm #(.WIDTH(WIDTH), .DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
        .pins_sync(pins_sync), .latch_q(latch_q), .dir_q(dir_q), .ansel_q(ansel_q),
        .rdata(rdata), .rvalid(rvalid)
    );

    assign pin_out = latch_q;
    assign pin_oe  = ~dir_q;

    // R5: both latch aliases load the driven value
    p_latch_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADR_PINS || addr == ADR_LATCH)) |=> pin_out == $past(wdata[WIDTH-1:0]));
    // R7: drivers change only through a direction write
    p_oe_only_by_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADR_DIR) |=> $stable(pin_oe));
    // R2: a direction write sets enables to its inverse
    p_oe_from_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_DIR) |=> pin_oe == ~$past(wdata[WIDTH-1:0]));
endmodule

// File: tb/sim_gpio_tri_port.sv
module sim_gpio_tri_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rvalid;
    logic [2:0] pin_in = '0;
    logic [2:0] pin_out, pin_oe;

    int n_chk = 0, n_bad = 0;
    logic [2:0] m_lat = 3'b000, m_dir = 3'b111, m_an = 3'b111;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_tri_port u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] exp_read(input logic [2:0] a, input logic [2:0] pins);
        case (a)
            3'd0:    return {5'b0, pins & ~m_an};
            3'd1:    return {5'b0, m_lat};
            3'd2:    return {5'b0, m_dir};
            3'd3:    return {5'b0, m_an};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, {29'b0, pin_out}, {29'b0, m_lat});
        check(req, {29'b0, pin_oe}, {29'b0, ~m_dir});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            3'd0, 3'd1: m_lat = d[2:0];
            3'd2:       m_dir = d[2:0];
            3'd3:       m_an  = d[2:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        e = exp_read(a, pin_in);
        @(negedge clk);
        rd_en = 1'b0;
        check("R9", {31'b0, rvalid}, 32'd1);
        check(req, {24'b0, rdata}, {24'b0, e});
        @(negedge clk);
        check("R9", {31'b0, rvalid}, 32'd0);
    endtask

    task automatic set_pins(input logic [2:0] p);
        @(negedge clk);
        pin_in = p;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [2:0] a;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {29'b0, pin_oe}, 32'd0);
        check("R1", {29'b0, pin_out}, 32'd0);
        check("R1", {31'b0, rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd2, "R1");
        rd(3'd3, "R1");
        set_pins(3'b101);
        rd(3'd0, "R6");  // all analog: reads zero

        // R2: single-bit and mixed direction patterns
        wr(3'd2, 8'h06); check_outputs("R2");
        wr(3'd2, 8'h05); check_outputs("R2");
        wr(3'd2, 8'h02); check_outputs("R2");
        // R3, R5: both latch aliases
        wr(3'd1, 8'h03); check_outputs("R3");
        wr(3'd0, 8'hFC); check_outputs("R5");
        // R4: latch read ignores pins
        set_pins(~m_lat);
        rd(3'd1, "R4");
        // R7: analog select leaves drivers alone
        wr(3'd3, 8'h00); check_outputs("R7");
        wr(3'd3, 8'h07); check_outputs("R7");
        // R6: per-bit masking
        wr(3'd3, 8'h02);
        set_pins(3'b111);
        rd(3'd0, "R6");
        // R8: unmapped addresses
        for (int k = 4; k < 8; k++) begin
            wr(3'(k), 8'hFF);
            rd(3'(k), "R8");
            rd(3'd1, "R8");
            rd(3'd2, "R8");
            rd(3'd3, "R8");
            check_outputs("R8");
        end
        // R9: back-to-back reads
        @(negedge clk);
        addr = 3'd2; rd_en = 1'b1;
        @(negedge clk);
        check("R9", {31'b0, rvalid}, 32'd1);
        addr = 3'd3;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9", {31'b0, rvalid}, 32'd1);
        check("R10", {24'b0, rdata}, {29'b0, m_an});
        @(negedge clk);
        check("R9", {31'b0, rvalid}, 32'd0);

        // random mix, R10 and R6 against the model
        for (int i = 0; i < 300; i++) begin
            set_pins(3'($urandom));
            a = 3'($urandom_range(0, 4));
            if ($urandom_range(0, 1) == 0) begin
                wr(a, 8'($urandom));
                check_outputs("R10");
            end else begin
                rd(a, (a == 3'd0) ? "R6" : "R10");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule